// File: doc/BRIEF.md
# SATA Port Task-File Shadow Registers

This block is a register slice for a single port of a SATA host controller. It holds two host-visible shadow registers. The task-file register carries the device error and status bytes, and the signature register identifies the attached device. The host never sees live device state. Each shadow changes only when the receive path reports a device-to-host FIS event, so a read issued before the port is running returns the reset contents and not some value that is still in flight.

The host reaches the registers through a simple byte-addressed read/write port. Every register here is read-only, so writes are accepted and discarded. The receive path presents one event per cycle, made up of a kind code, an error byte and a status byte. For signature events it also presents the attach and device-type flags. Two interrupt-request outputs pulse for one cycle: one for an error reported by a register or PIO-setup event, and one for a set-device-bits event.

Top module: `sata_tf_shadow`

## Requirements
- R1: A low `rst_n` or a high `port_rst` at a clock edge loads the task-file shadow with 0x0000007F and the signature shadow with 0xFFFFFFFF, and clears both interrupt outputs. Events in that cycle are dropped.
- R2: Host writes to offsets 0x20 (task-file), 0x24 (signature) and 0x28 (link status) change nothing that can be read back.
- R3: A read at clock edge N places the register value on `reg_rdata` and raises `reg_rvalid` for one cycle after edge N. `reg_rdata` then holds until the next read. If an event arrives at the same edge, the read returns the value from before that event.
- R4: An event of kind 0 (register D2H) or kind 1 (PIO setup) sets task-file bits 15:8 to the error byte and bits 7:0 to the status byte.
- R5: An event of kind 2 (set-device-bits) replaces the error byte and sets the status byte to (old & 0x88) | (new & 0x77). BSY (bit 7) and DRQ (bit 3) therefore keep their previous values.
- R6: An event of kind 0 or kind 1 whose status bit 0 (ERR) is set makes `irq_tf_err` high for exactly the one cycle after the event edge.
- R7: An event of kind 2 makes `irq_set_bits` high for exactly the one cycle after the event edge.
- R8: An event of kind 3 (signature) loads the signature shadow with 0x00000000 when no device is attached, 0x00000101 for a disk, and 0xEB140101 for a packet device. It leaves the task-file shadow alone.
- R9: Bits 31:16 of the task-file register read as zero. Offsets that map to no register read as zero.
- R10: A read of offset 0x28 returns the `link_status` input as sampled at the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_rst | input | 1 | Port reset pulse, reloads the shadows |
| reg_wr | input | 1 | Host write strobe (discarded) |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Host write data (discarded) |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid pulse |
| fis_valid | input | 1 | Received-FIS event strobe |
| fis_kind | input | 2 | 0 register D2H, 1 PIO setup, 2 set-device-bits, 3 signature |
| fis_error | input | 8 | Error byte of the event |
| fis_status | input | 8 | Status byte of the event |
| dev_attached | input | 1 | Device present, used by signature events |
| dev_is_packet | input | 1 | Device is a packet device, used by signature events |
| link_status | input | 32 | Live link status word, read-only view |
| irq_tf_err | output | 1 | Task-file error interrupt pulse |
| irq_set_bits | output | 1 | Set-device-bits interrupt pulse |

## Verification
Every result of this block appears exactly one clock after the edge that samples its stimulus. A shadow update, an interrupt pulse and read data all become visible in the cycle after the event or the read. A shadow update only becomes observable through a read issued on a later edge. The bench changes inputs on the falling edge and steps a behavioural model at each rising edge. It computes the read-data result from the model's state before it applies that edge's event, and then compares outputs on the next falling edge, so the same-edge ordering is checked every cycle. Hand-computed constants back up the model at the corner cases: the reset values, the set-device-bits merge, and the three signature values.

// File: rtl/sata_tf_pkg.sv
package sata_tf_pkg;
   typedef enum logic [1:0] {
      FIS_REG_D2H   = 2'd0,
      FIS_PIO_SETUP = 2'd1,
      FIS_SET_BITS  = 2'd2,
      FIS_SIGNATURE = 2'd3
   } fis_kind_e;

   localparam logic [15:0] TF_RESET_VAL  = 16'h007F;
   localparam logic [31:0] SIG_RESET_VAL = 32'hFFFF_FFFF;
   localparam logic [31:0] SIG_NONE      = 32'h0000_0000;
   localparam logic [31:0] SIG_DISK      = 32'h0000_0101;
   localparam logic [31:0] SIG_PACKET    = 32'hEB14_0101;
   localparam logic [7:0]  STAT_ERR_BIT  = 8'h01;
endpackage

// File: rtl/tf_shadow_reg.sv
module tf_shadow_reg
   import sata_tf_pkg::*;
#(
   parameter int          BYTE_W    = 8,
   parameter logic [7:0]  KEEP_MASK = 8'h88
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                port_rst,
   input  logic                ev_valid,
   input  fis_kind_e           ev_kind,
   input  logic [BYTE_W-1:0]   ev_error,
   input  logic [BYTE_W-1:0]   ev_status,
   output logic [2*BYTE_W-1:0] tf_q,
   output logic                irq_err,
   output logic                irq_sdb
);
   localparam int TF_W = 2 * BYTE_W;

   if (BYTE_W != 8) begin : g_bad_width
      $error("tf_shadow_reg: BYTE_W must be 8");
   end

   logic [BYTE_W-1:0] merged_stat;
   logic              full_load;
   logic              sdb_load;

   // Per-bit merge: kept bits hold the old value, the rest take the new one.
   for (genvar b = 0; b < BYTE_W; b++) begin : g_merge
      if (KEEP_MASK[b]) begin : g_keep
         assign merged_stat[b] = tf_q[b];
      end else begin : g_take
         assign merged_stat[b] = ev_status[b];
      end
   end

   assign full_load = ev_valid && (ev_kind == FIS_REG_D2H || ev_kind == FIS_PIO_SETUP);
   assign sdb_load  = ev_valid && (ev_kind == FIS_SET_BITS);

   always_ff @(posedge clk) begin
      if (!rst_n || port_rst) begin
         tf_q    <= TF_RESET_VAL[TF_W-1:0];
         irq_err <= 1'b0;
         irq_sdb <= 1'b0;
      end else begin
         irq_err <= full_load && ((ev_status & STAT_ERR_BIT) != '0);
         irq_sdb <= sdb_load;
         if (full_load) begin
            tf_q <= {ev_error, ev_status};
         end else if (sdb_load) begin
            tf_q <= {ev_error, merged_stat};
         end
      end
   end
endmodule

// File: rtl/sig_shadow_reg.sv
module sig_shadow_reg
   import sata_tf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_rst,
   input  logic              ev_valid,
   input  fis_kind_e         ev_kind,
   input  logic              dev_attached,
   input  logic              dev_is_packet,
   output logic [DATA_W-1:0] sig_q
);
   if (DATA_W != 32) begin : g_bad_width
      $error("sig_shadow_reg: DATA_W must be 32");
   end

   logic [DATA_W-1:0] sig_next;

   always_comb begin
      if (!dev_attached)     sig_next = SIG_NONE;
      else if (dev_is_packet) sig_next = SIG_PACKET;
      else                    sig_next = SIG_DISK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || port_rst) begin
         sig_q <= SIG_RESET_VAL;
      end else if (ev_valid && ev_kind == FIS_SIGNATURE) begin
         sig_q <= sig_next;
      end
   end
endmodule

// File: rtl/tf_reg_read.sv
module tf_reg_read #(
   parameter int              ADDR_W   = 8,
   parameter int              DATA_W   = 32,
   parameter int              TF_W     = 16,
   parameter logic [ADDR_W-1:0] TF_OFF   = 8'h20,
   parameter logic [ADDR_W-1:0] SIG_OFF  = 8'h24,
   parameter logic [ADDR_W-1:0] LINK_OFF = 8'h28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [TF_W-1:0]   tf_q,
   input  logic [DATA_W-1:0] sig_q,
   input  logic [DATA_W-1:0] link_status,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   localparam int WORD_LSB = 2;

   if (TF_W > DATA_W) begin : g_bad_tf
      $error("tf_reg_read: TF_W exceeds DATA_W");
   end
   if (ADDR_W <= WORD_LSB) begin : g_bad_addr
      $error("tf_reg_read: ADDR_W too small");
   end

   logic [ADDR_W-WORD_LSB-1:0] word;
   logic [DATA_W-1:0]          mux;

   assign word = addr[ADDR_W-1:WORD_LSB];

   always_comb begin
      if (word == TF_OFF[ADDR_W-1:WORD_LSB])        mux = {{(DATA_W-TF_W){1'b0}}, tf_q};
      else if (word == SIG_OFF[ADDR_W-1:WORD_LSB])  mux = sig_q;
      else if (word == LINK_OFF[ADDR_W-1:WORD_LSB]) mux = link_status;
      else                                          mux = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= rd;
         if (rd) rdata <= mux;
      end
   end
endmodule

// File: rtl/sata_tf_shadow.sv
module sata_tf_shadow
   import sata_tf_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_rst,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              reg_rvalid,
   input  logic              fis_valid,
   input  logic [1:0]        fis_kind,
   input  logic [BYTE_W-1:0] fis_error,
   input  logic [BYTE_W-1:0] fis_status,
   input  logic              dev_attached,
   input  logic              dev_is_packet,
   input  logic [DATA_W-1:0] link_status,
   output logic              irq_tf_err,
   output logic              irq_set_bits
);
   localparam int TF_W = 2 * BYTE_W;

   fis_kind_e         kind;
   logic [TF_W-1:0]   tf_q;
   logic [DATA_W-1:0] sig_q;
   logic              unused_wr;

   assign kind = fis_kind_e'(fis_kind);
   // Every register in this slice is read-only: write traffic is discarded.
   assign unused_wr = reg_wr ^ (^reg_wdata);

   tf_shadow_reg #(.BYTE_W(BYTE_W), .KEEP_MASK(8'h88)) u_tf (
      .clk(clk), .rst_n(rst_n), .port_rst(port_rst),
      .ev_valid(fis_valid), .ev_kind(kind),
      .ev_error(fis_error), .ev_status(fis_status),
      .tf_q(tf_q), .irq_err(irq_tf_err), .irq_sdb(irq_set_bits)
   );

   sig_shadow_reg #(.DATA_W(DATA_W)) u_sig (
      .clk(clk), .rst_n(rst_n), .port_rst(port_rst),
      .ev_valid(fis_valid), .ev_kind(kind),
      .dev_attached(dev_attached), .dev_is_packet(dev_is_packet),
      .sig_q(sig_q)
   );

   tf_reg_read #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TF_W(TF_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd(reg_rd), .addr(reg_addr),
      .tf_q(tf_q), .sig_q(sig_q), .link_status(link_status),
      .rdata(reg_rdata), .rvalid(reg_rvalid)
   );
endmodule

// File: rtl/sata_tf_shadow_chk.sv
module sata_tf_shadow_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              port_rst,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              reg_rvalid,
   input logic              fis_valid,
   input logic [1:0]        fis_kind,
   input logic [7:0]        fis_status,
   input logic [15:0]       tf_q,
   input logic [DATA_W-1:0] sig_q,
   input logic              irq_tf_err,
   input logic              irq_set_bits
);
   logic live_ev;
   assign live_ev = fis_valid && !port_rst;

   assert_port_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      port_rst |=> (tf_q == 16'h007F && sig_q == 32'hFFFF_FFFF && !irq_tf_err && !irq_set_bits));

   assert_ro_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !fis_valid && !port_rst) |=> ($stable(tf_q) && $stable(sig_q)));

   assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rvalid);

   assert_sdb_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (live_ev && fis_kind == 2'd2) |=> (tf_q[7] == $past(tf_q[7]) && tf_q[3] == $past(tf_q[3])));

   assert_tferr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (live_ev && fis_kind[1] == 1'b0 && fis_status[0]) |=> irq_tf_err);

   assert_tferr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(live_ev && fis_kind[1] == 1'b0 && fis_status[0]) |=> !irq_tf_err);

   assert_sdb_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (live_ev && fis_kind == 2'd2) |=> irq_set_bits);

   assert_sdb_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(live_ev && fis_kind == 2'd2) |=> !irq_set_bits);

   assert_tf_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr[7:2] == 6'h08) |=> reg_rdata[31:16] == 16'h0000);
endmodule

bind sata_tf_shadow sata_tf_shadow_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
   .fis_valid(fis_valid), .fis_kind(fis_kind), .fis_status(fis_status),
   .tf_q(tf_q), .sig_q(sig_q), .irq_tf_err(irq_tf_err), .irq_set_bits(irq_set_bits)
);

// File: tb/sata_tf_shadow_tb.sv
module sata_tf_shadow_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_rst = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_rvalid;
   logic        fis_valid = 1'b0;
   logic [1:0]  fis_kind = '0;
   logic [7:0]  fis_error = '0;
   logic [7:0]  fis_status = '0;
   logic        dev_attached = 1'b0;
   logic        dev_is_packet = 1'b0;
   logic [31:0] link_status = '0;
   logic        irq_tf_err;
   logic        irq_set_bits;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   logic [15:0] m_tf = 16'h007F;
   logic [31:0] m_sig = 32'hFFFF_FFFF;
   logic [31:0] m_rdata = '0;
   logic        m_rvalid = 0;
   logic        m_irq_e = 0;
   logic        m_irq_s = 0;

   always #4 clk = ~clk;

   sata_tf_shadow u_dut (
      .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_rvalid(reg_rvalid), .fis_valid(fis_valid), .fis_kind(fis_kind),
      .fis_error(fis_error), .fis_status(fis_status), .dev_attached(dev_attached),
      .dev_is_packet(dev_is_packet), .link_status(link_status),
      .irq_tf_err(irq_tf_err), .irq_set_bits(irq_set_bits)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic model_edge();
      if (!rst_n) begin
         m_tf = 16'h007F; m_sig = 32'hFFFF_FFFF; m_rdata = '0;
         m_rvalid = 0; m_irq_e = 0; m_irq_s = 0;
         return;
      end
      m_rvalid = reg_rd;
      if (reg_rd) begin
         case (reg_addr[7:2])
            6'h08:   m_rdata = {16'h0, m_tf};
            6'h09:   m_rdata = m_sig;
            6'h0A:   m_rdata = link_status;
            default: m_rdata = '0;
         endcase
      end
      if (port_rst) begin
         m_tf = 16'h007F; m_sig = 32'hFFFF_FFFF; m_irq_e = 0; m_irq_s = 0;
         return;
      end
      m_irq_e = fis_valid && fis_kind < 2 && fis_status[0];
      m_irq_s = fis_valid && fis_kind == 2;
      if (fis_valid) begin
         if (fis_kind < 2) m_tf = {fis_error, fis_status};
         else if (fis_kind == 2) m_tf = {fis_error, (m_tf[7:0] & 8'h88) | (fis_status & 8'h77)};
         else m_sig = !dev_attached ? 32'h0 : (dev_is_packet ? 32'hEB140101 : 32'h00000101);
      end
   endtask

   // One cycle: inputs already driven; model steps at the rising edge,
   // outputs compared at the following falling edge; pulses then cleared.
   task automatic step(input string req);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check({req, " rdata"}, reg_rdata, m_rdata);
      check({req, " rvalid"}, {31'h0, reg_rvalid}, {31'h0, m_rvalid});
      check({req, " irq_tf_err"}, {31'h0, irq_tf_err}, {31'h0, m_irq_e});
      check({req, " irq_set_bits"}, {31'h0, irq_set_bits}, {31'h0, m_irq_s});
      reg_rd = 0; reg_wr = 0; fis_valid = 0; port_rst = 0;
   endtask

   task automatic do_read(input logic [7:0] a, input string req);
      reg_rd = 1; reg_addr = a;
      step(req);
   endtask

   task automatic do_fis(input logic [1:0] k, input logic [7:0] e, input logic [7:0] s, input string req);
      fis_valid = 1; fis_kind = k; fis_error = e; fis_status = s;
      step(req);
   endtask

   initial begin
      for (int i = 0; i < 200000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) begin @(negedge clk); model_edge(); end
      rst_n = 1;
      // R1: reset values through reads
      do_read(8'h20, "R1");
      check("R1 tf reset", reg_rdata, 32'h0000007F);
      do_read(8'h24, "R1");
      check("R1 sig reset", reg_rdata, 32'hFFFFFFFF);
      // R2: writes ignored
      reg_wr = 1; reg_addr = 8'h20; reg_wdata = 32'h1234_5678; step("R2");
      reg_wr = 1; reg_addr = 8'h24; reg_wdata = 32'h0; step("R2");
      reg_wr = 1; reg_addr = 8'h28; reg_wdata = 32'hFFFF_FFFF; step("R2");
      do_read(8'h20, "R2");
      check("R2 tf after write", reg_rdata, 32'h0000007F);
      do_read(8'h24, "R2");
      check("R2 sig after write", reg_rdata, 32'hFFFFFFFF);
      // R4, R6: register D2H with ERR
      do_fis(2'd0, 8'h04, 8'h51, "R6");
      check("R6 irq_tf_err pulse", {31'h0, irq_tf_err}, 32'h1);
      step("R6 one-cycle");
      check("R6 irq_tf_err drops", {31'h0, irq_tf_err}, 32'h0);
      do_read(8'h20, "R4");
      check("R4 d2h tf", reg_rdata, 32'h00000451);
      // R4: PIO setup, no ERR
      do_fis(2'd1, 8'h00, 8'hD8, "R4");
      check("R6 no irq without ERR", {31'h0, irq_tf_err}, 32'h0);
      do_read(8'h20, "R4");
      check("R4 pio tf", reg_rdata, 32'h000000D8);
      // R5, R7: set-device-bits merge keeps BSY/DRQ
      do_fis(2'd2, 8'h10, 8'h21, "R7");
      check("R7 irq_set_bits pulse", {31'h0, irq_set_bits}, 32'h1);
      do_read(8'h20, "R5");
      check("R5 sdb merge", reg_rdata, 32'h000010A9);
      do_fis(2'd2, 8'h00, 8'h00, "R5");
      do_fis(2'd2, 8'h33, 8'hFF, "R5");
      do_read(8'h20, "R5");
      check("R5 sdb merge 2", reg_rdata, 32'h000033FF);
      // R3: read and event at the same edge
      reg_rd = 1; reg_addr = 8'h20;
      fis_valid = 1; fis_kind = 2'd0; fis_error = 8'h00; fis_status = 8'h50;
      step("R3");
      check("R3 old value", reg_rdata, 32'h000033FF);
      step("R3 hold");
      check("R3 rdata held", reg_rdata, 32'h000033FF);
      do_read(8'h20, "R3");
      check("R3 new value", reg_rdata, 32'h00000050);
      // R8: signatures
      dev_attached = 0; do_fis(2'd3, 8'h00, 8'h00, "R8");
      do_read(8'h24, "R8");
      check("R8 no device", reg_rdata, 32'h00000000);
      dev_attached = 1; dev_is_packet = 0; do_fis(2'd3, 8'h00, 8'h00, "R8");
      do_read(8'h24, "R8");
      check("R8 disk", reg_rdata, 32'h00000101);
      dev_is_packet = 1; do_fis(2'd3, 8'h00, 8'h00, "R8");
      do_read(8'h24, "R8");
      check("R8 packet", reg_rdata, 32'hEB140101);
      do_read(8'h20, "R8");
      check("R8 tf untouched", reg_rdata, 32'h00000050);
      // R9, R10
      do_read(8'h30, "R9");
      check("R9 unmapped", reg_rdata, 32'h0);
      link_status = 32'h0000_0123;
      do_read(8'h28, "R10");
      check("R10 link status", reg_rdata, 32'h00000123);
      // R1: port reset drops same-cycle event
      port_rst = 1; fis_valid = 1; fis_kind = 2'd2; fis_status = 8'hFF;
      step("R1");
      check("R1 no irq in reset", {31'h0, irq_set_bits}, 32'h0);
      do_read(8'h20, "R1");
      check("R1 tf after port reset", reg_rdata, 32'h0000007F);
      do_read(8'h24, "R1");
      check("R1 sig after port reset", reg_rdata, 32'hFFFFFFFF);
      // patterned sweep
      for (int i = 0; i < 40; i++) begin
         fis_valid = 1; fis_kind = 2'(i % 3);
         fis_error = 8'(i * 37); fis_status = 8'(i * 91 + 5);
         reg_rd = (i % 2 == 0); reg_addr = 8'h20;
         step("R4 sweep");
      end
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule